// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block gives a host a byte-wide path into a small set of configuration registers through two adjacent I/O addresses: an index port and a data port. Configuration access stays closed until the host writes a two-byte key to the index port. While access is open, each index-port write chooses a register, and data-port reads and writes then reach that register. Writing an exit byte to the index port closes access again.

Registers are split into two groups. Indices below 30h are global and are shared by every function. Indices from 30h upward reach a banked set that belongs to the logical device currently named in the device-number register. The address pair is picked by a select bit whose reset value comes from a strap pin sampled during reset. A lock bit freezes every register except the one that holds the lock. A write-only register triggers a soft reset of the register contents. Two read-only bytes give a device identity. The banked register contents and the per-interface power-enable bits leave the block as plain outputs.

Top module: `cfg_port`

## Requirements
- R1: Configuration mode (`cfg_mode` = 1) is entered only after two consecutive index-port writes of 83h. `cfg_mode` is high from the clock edge that takes the second write. Any other value written to the index port in between restarts the key.
- R2: While in configuration mode, an index-port write of AAh leaves configuration mode from the next clock edge. Any other index-port write is latched as the current register index.
- R3: Outside configuration mode, data-port writes change no register and data-port reads return 00h.
- R4: The index/data ports are 2Eh/2Fh when bit 6 of register 26h is 0, and 4Eh/4Fh when that bit is 1. After a hardware reset, register 26h holds bit 6 equal to the inverse of the `strap` level sampled while reset is applied, with all other bits 0.
- R5: A data-port read returns the register chosen by the last index write. An index-port read always returns 00h.
- R6: Register 07h holds the logical device number: its low 2 bits are stored and the upper bits read 0. Indices 30h to 33h reach a separate 4-byte bank for each of the 4 devices. Byte k of device d appears on `bank_regs[(d*4+k)*8 +: 8]`.
- R7: Global indices (00h to 2Fh) read and write the same storage whatever device number is selected.
- R8: Register 20h reads 71h and register 21h reads {1h, REV}, with REV = 3h by default. Writes to both have no effect.
- R9: Register 02h reads 00h. Writing it with bit 0 = 1 restores the hardware-reset values of 07h, 22h, 26h and every bank byte, with bit 6 of 26h taken from the strap value captured at the last hardware reset. Configuration mode is left as it was.
- R10: Register 22h stores bits 7, 6 and 5, and its other bits read 0. It resets to 80h. `if_on[2]`, `if_on[1]` and `if_on[0]` follow bits 7, 6 and 5, where 0 means the interface is powered down.
- R11: While bit 5 of 26h (the lock) is 1, data-port writes to any index other than 26h have no effect, soft reset included. A write to 26h can still clear the lock, and the AAh exit still works.
- R12: Data-port reads of indices that are not defined return 00h, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| strap | input | 1 | Port-pair strap, sampled while reset is applied |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_rd | input | 1 | I/O read strobe |
| io_addr | input | 8 | I/O address |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Read data, valid while io_rd is high (combinational) |
| cfg_mode | output | 1 | Configuration mode is open |
| if_on | output | 3 | Interface power enables from register 22h bits 7:5 |
| bank_regs | output | 128 | All banked bytes, device-major and byte-minor |

## Verification
The hardest states to reach are the ones where the port address has moved. This happens after a write to bit 6 of 26h, after a hardware reset with the strap high, and after a soft reset that pulls the address back from the captured strap. Each of these leaves later accesses landing on the other address pair. The stimulus reaches them by resetting with the strap at each level, checking that the key is ignored on the wrong pair, and then moving the pair in mid-session by both a register write and a soft reset. A second hard case is the locked state. The stimulus sets the lock and then tries power, bank, device-number and soft-reset writes, and reads the outputs after each one, before releasing the lock through 26h.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
    localparam logic [7:0] KEY_OPEN  = 8'h83;
    localparam logic [7:0] KEY_CLOSE = 8'hAA;
    localparam logic [7:0] IX_SRST   = 8'h02;
    localparam logic [7:0] IX_DEVNUM = 8'h07;
    localparam logic [7:0] IX_IDHI   = 8'h20;
    localparam logic [7:0] IX_IDLO   = 8'h21;
    localparam logic [7:0] IX_POWER  = 8'h22;
    localparam logic [7:0] IX_OPTS   = 8'h26;
    localparam logic [7:0] IX_BANK0  = 8'h30;
    localparam logic [7:0] ID_UPPER  = 8'h71;
    localparam logic [3:0] ID_FAMILY = 4'h1;
    localparam logic [7:0] PAIR_LO   = 8'h2E;
    localparam logic [7:0] PAIR_HI   = 8'h4E;

    typedef enum logic [1:0] {
        ST_SHUT = 2'd0,
        ST_HALF = 2'd1,
        ST_OPEN = 2'd2
    } seq_e;
endpackage

// File: rtl/cfg_port_seq.sv
module cfg_port_seq
    import cfg_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       cfg_open,
    output logic [7:0] cur_idx
);
    typedef struct packed {
        seq_e       st;
        logic [7:0] idx;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (idx_wr) begin
            case (s_q.st)
                ST_SHUT: s_d.st = (wdata == KEY_OPEN) ? ST_HALF : ST_SHUT;
                ST_HALF: s_d.st = (wdata == KEY_OPEN) ? ST_OPEN : ST_SHUT;
                ST_OPEN: begin
                    if (wdata == KEY_CLOSE) begin
                        s_d.st  = ST_SHUT;
                        s_d.idx = 8'h00;
                    end else begin
                        s_d.idx = wdata;
                    end
                end
                default: s_d.st = ST_SHUT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: ST_SHUT, idx: 8'h00};
        else        s_q <= s_d;
    end

    assign cfg_open = (s_q.st == ST_OPEN);
    assign cur_idx  = s_q.idx;
endmodule

// File: rtl/cfg_port_bank.sv
module cfg_port_bank #(
    parameter int NDEV  = 4,
    parameter int DEPTH = 4,
    parameter int DW    = 8,
    localparam int DEV_W  = (NDEV > 1) ? $clog2(NDEV) : 1,
    localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       wr_en,
    input  logic [DEV_W-1:0]           dev,
    input  logic [SLOT_W-1:0]          slot,
    input  logic [DW-1:0]              wdata,
    output logic [DW-1:0]              rdata,
    output logic [NDEV*DEPTH*DW-1:0]   flat
);
    logic [NDEV-1:0][DEPTH-1:0][DW-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (clr)        mem_d = '0;
        else if (wr_en) mem_d[dev][slot] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign rdata = mem_q[dev][slot];
    assign flat  = mem_q;
endmodule

// File: rtl/cfg_port.sv
module cfg_port
    import cfg_port_pkg::*;
#(
    parameter int         NDEV       = 4,
    parameter int         BANK_DEPTH = 4,
    parameter logic [3:0] REV        = 4'h3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          strap,
    input  logic                          io_wr,
    input  logic                          io_rd,
    input  logic [7:0]                    io_addr,
    input  logic [7:0]                    io_wdata,
    output logic [7:0]                    io_rdata,
    output logic                          cfg_mode,
    output logic [2:0]                    if_on,
    output logic [NDEV*BANK_DEPTH*8-1:0]  bank_regs
);
    localparam int DEV_W  = (NDEV > 1) ? $clog2(NDEV) : 1;
    localparam int SLOT_W = (BANK_DEPTH > 1) ? $clog2(BANK_DEPTH) : 1;

    typedef struct packed {
        logic [DEV_W-1:0] devnum;
        logic [2:0]       power;
        logic             pair_sel;
        logic             lock;
        logic             strap_cap;
    } glb_t;

    glb_t glb_d, glb_q;

    logic [7:0] idx_port, dat_port, cur_index, bank_off, bank_rd, rd_val;
    logic       idx_wr, dat_wr, wr_ok, in_bank, soft_rst, lock_on;

    assign idx_port = glb_q.pair_sel ? PAIR_HI : PAIR_LO;
    assign dat_port = idx_port + 8'd1;
    assign idx_wr   = io_wr && (io_addr == idx_port);
    assign lock_on  = glb_q.lock;

    cfg_port_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (idx_wr),
        .wdata    (io_wdata),
        .cfg_open (cfg_mode),
        .cur_idx  (cur_index)
    );

    assign dat_wr   = io_wr && (io_addr == dat_port) && cfg_mode;
    assign wr_ok    = dat_wr && (!glb_q.lock || (cur_index == IX_OPTS));
    assign bank_off = cur_index - IX_BANK0;
    assign in_bank  = (cur_index >= IX_BANK0) && (32'(bank_off) < 32'(BANK_DEPTH));
    assign soft_rst = wr_ok && (cur_index == IX_SRST) && io_wdata[0];

    cfg_port_bank #(
        .NDEV  (NDEV),
        .DEPTH (BANK_DEPTH),
        .DW    (8)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (soft_rst),
        .wr_en (wr_ok && in_bank),
        .dev   (glb_q.devnum),
        .slot  (bank_off[SLOT_W-1:0]),
        .wdata (io_wdata),
        .rdata (bank_rd),
        .flat  (bank_regs)
    );

    always_comb begin
        glb_d = glb_q;
        if (soft_rst) begin
            glb_d.devnum   = '0;
            glb_d.power    = 3'b100;
            glb_d.pair_sel = ~glb_q.strap_cap;
            glb_d.lock     = 1'b0;
        end else if (wr_ok) begin
            case (cur_index)
                IX_DEVNUM: glb_d.devnum = io_wdata[DEV_W-1:0];
                IX_POWER:  glb_d.power  = io_wdata[7:5];
                IX_OPTS: begin
                    glb_d.pair_sel = io_wdata[6];
                    glb_d.lock     = io_wdata[5];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glb_q <= '{devnum: '0, power: 3'b100, pair_sel: ~strap,
                       lock: 1'b0, strap_cap: strap};
        end else begin
            glb_q <= glb_d;
        end
    end

    always_comb begin
        rd_val = 8'h00;
        case (cur_index)
            IX_DEVNUM: rd_val = 8'(glb_q.devnum);
            IX_IDHI:   rd_val = ID_UPPER;
            IX_IDLO:   rd_val = {ID_FAMILY, REV};
            IX_POWER:  rd_val = {glb_q.power, 5'b0};
            IX_OPTS:   rd_val = {1'b0, glb_q.pair_sel, glb_q.lock, 5'b0};
            default:   if (in_bank) rd_val = bank_rd;
        endcase
    end

    assign io_rdata = (io_rd && cfg_mode && (io_addr == dat_port)) ? rd_val : 8'h00;
    assign if_on    = glb_q.power;
endmodule

// File: rtl/cfg_port_chk.sv
module cfg_port_chk #(
    parameter int BW = 128
) (
    input logic          clk,
    input logic          rst_n,
    input logic          io_wr,
    input logic          io_rd,
    input logic [7:0]    io_addr,
    input logic [7:0]    io_wdata,
    input logic [7:0]    io_rdata,
    input logic          cfg_mode,
    input logic [2:0]    if_on,
    input logic [BW-1:0] bank_regs,
    input logic [7:0]    idx_port,
    input logic [7:0]    dat_port,
    input logic [7:0]    cur_index,
    input logic          lock_on
);
    p_enter_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_mode) |-> $past(io_wr && io_wdata == 8'h83));

    p_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode && io_wr && io_addr == idx_port && io_wdata == 8'hAA) |=> !cfg_mode);

    p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mode |-> (io_rdata == 8'h00));

    p_idhi_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode && io_rd && io_addr == dat_port && cur_index == 8'h20) |-> (io_rdata == 8'h71));

    p_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        lock_on |=> ($stable(if_on) && $stable(bank_regs)));

    p_closed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mode |=> ($stable(if_on) && $stable(bank_regs)));
endmodule

bind cfg_port cfg_port_chk #(.BW(NDEV*BANK_DEPTH*8)) u_chk (.*);

// File: tb/cfg_port_test.sv
module cfg_port_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         strap = 1'b0;
    logic         io_wr = 1'b0;
    logic         io_rd = 1'b0;
    logic [7:0]   io_addr = 8'h00;
    logic [7:0]   io_wdata = 8'h00;
    logic [7:0]   io_rdata;
    logic         cfg_mode;
    logic [2:0]   if_on;
    logic [127:0] bank_regs;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cfg_port uut (
        .clk(clk), .rst_n(rst_n), .strap(strap), .io_wr(io_wr), .io_rd(io_rd),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .cfg_mode(cfg_mode), .if_on(if_on), .bank_regs(bank_regs)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic hw_reset(input logic s);
        @(negedge clk);
        rst_n = 1'b0;
        strap = s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        strap = ~s;
    endtask

    task automatic iow(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic ior(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        io_rd = 1'b1; io_addr = a;
        #1 d = io_rdata;
        io_rd = 1'b0;
    endtask

    function automatic logic [7:0] bank_byte(input int dv, input int k);
        return bank_regs[(dv*4+k)*8 +: 8];
    endfunction

    task automatic t_reset;
        logic [7:0] v;
        hw_reset(1'b0);
        chk("R1 reset mode", 128'(cfg_mode), 128'd0);
        chk("R10 reset power", 128'(if_on), 128'b100);
        chk("R6 reset banks", bank_regs, 128'd0);
        ior(8'h4F, v);
        chk("R3 closed read", 128'(v), 128'd0);
    endtask

    task automatic t_unlock;
        logic [7:0] v;
        iow(8'h2E, 8'h83); iow(8'h2E, 8'h83);
        chk("R4 wrong pair ignored", 128'(cfg_mode), 128'd0);
        iow(8'h4E, 8'h83); iow(8'h4E, 8'h55); iow(8'h4E, 8'h83);
        chk("R1 broken key", 128'(cfg_mode), 128'd0);
        iow(8'h4E, 8'h83); iow(8'h4E, 8'h83);
        chk("R1 key accepted", 128'(cfg_mode), 128'd1);
        iow(8'h4E, 8'h26); ior(8'h4F, v);
        chk("R4 opts reset strap0", 128'(v), 128'h40);
        iow(8'h4E, 8'h20); ior(8'h4F, v);
        chk("R8 id high", 128'(v), 128'h71);
        iow(8'h4E, 8'h21); iow(8'h4F, 8'h00); ior(8'h4F, v);
        chk("R8 id low after write", 128'(v), 128'h13);
        ior(8'h4E, v);
        chk("R5 index port read", 128'(v), 128'd0);
    endtask

    task automatic t_closed;
        logic [7:0] v;
        iow(8'h4E, 8'hAA);
        chk("R2 exit", 128'(cfg_mode), 128'd0);
        iow(8'h4F, 8'h00);
        ior(8'h4F, v);
        chk("R3 closed read", 128'(v), 128'd0);
        chk("R3 closed write power", 128'(if_on), 128'b100);
        chk("R3 closed write bank", bank_regs, 128'd0);
        iow(8'h4E, 8'h83); iow(8'h4E, 8'h83);
        iow(8'h4E, 8'h22); ior(8'h4F, v);
        chk("R3 power kept", 128'(v), 128'h80);
    endtask

    task automatic t_bank;
        logic [7:0] v;
        iow(8'h4E, 8'h07); iow(8'h4F, 8'h01);
        iow(8'h4E, 8'h30); iow(8'h4F, 8'hA5);
        iow(8'h4E, 8'h33); iow(8'h4F, 8'h3C);
        iow(8'h4E, 8'h07); iow(8'h4F, 8'h02);
        iow(8'h4E, 8'h30); iow(8'h4F, 8'h5A);
        chk("R6 dev1 byte0", 128'(bank_byte(1, 0)), 128'hA5);
        chk("R6 dev1 byte3", 128'(bank_byte(1, 3)), 128'h3C);
        chk("R6 dev2 byte0", 128'(bank_byte(2, 0)), 128'h5A);
        chk("R6 dev0 byte0", 128'(bank_byte(0, 0)), 128'h00);
        ior(8'h4F, v);
        chk("R5 read dev2 byte0", 128'(v), 128'h5A);
        iow(8'h4E, 8'h07); iow(8'h4F, 8'h01);
        iow(8'h4E, 8'h30); ior(8'h4F, v);
        chk("R6 read dev1 byte0", 128'(v), 128'hA5);
        iow(8'h4E, 8'h07); iow(8'h4F, 8'h06); ior(8'h4F, v);
        chk("R6 devnum low bits", 128'(v), 128'h02);
    endtask

    task automatic t_global;
        logic [7:0] v;
        iow(8'h4E, 8'h07); iow(8'h4F, 8'h03);
        iow(8'h4E, 8'h22); iow(8'h4F, 8'hFF); ior(8'h4F, v);
        chk("R10 power bits", 128'(v), 128'hE0);
        chk("R10 if_on all", 128'(if_on), 128'b111);
        iow(8'h4E, 8'h07); iow(8'h4F, 8'h00);
        iow(8'h4E, 8'h22); ior(8'h4F, v);
        chk("R7 global across dev", 128'(v), 128'hE0);
        iow(8'h4F, 8'h20);
        chk("R10 if_on bit0", 128'(if_on), 128'b001);
        iow(8'h4E, 8'h40); iow(8'h4F, 8'h99); ior(8'h4F, v);
        chk("R12 unused index", 128'(v), 128'd0);
        chk("R12 unused write", 128'(bank_byte(0, 0)), 128'h00);
    endtask

    task automatic t_soft;
        logic [7:0] v;
        iow(8'h4E, 8'h02); ior(8'h4F, v);
        chk("R9 srst reads zero", 128'(v), 128'd0);
        iow(8'h4F, 8'h01);
        chk("R9 banks cleared", bank_regs, 128'd0);
        chk("R9 power restored", 128'(if_on), 128'b100);
        chk("R9 mode kept", 128'(cfg_mode), 128'd1);
        iow(8'h4E, 8'h07); ior(8'h4F, v);
        chk("R9 devnum cleared", 128'(v), 128'd0);
    endtask

    task automatic t_lock;
        iow(8'h4E, 8'h22); iow(8'h4F, 8'h00);
        iow(8'h4E, 8'h26); iow(8'h4F, 8'h60);
        iow(8'h4E, 8'h22); iow(8'h4F, 8'hE0);
        chk("R11 power frozen", 128'(if_on), 128'b000);
        iow(8'h4E, 8'h30); iow(8'h4F, 8'h77);
        chk("R11 bank frozen", bank_regs, 128'd0);
        iow(8'h4E, 8'h02); iow(8'h4F, 8'h01);
        chk("R11 srst blocked", 128'(if_on), 128'b000);
        iow(8'h4E, 8'h26); iow(8'h4F, 8'h40);
        iow(8'h4E, 8'h22); iow(8'h4F, 8'hE0);
        chk("R11 unlocked write", 128'(if_on), 128'b111);
        iow(8'h4E, 8'h26); iow(8'h4F, 8'h60);
        iow(8'h4E, 8'hAA);
        chk("R11 exit while locked", 128'(cfg_mode), 128'd0);
    endtask

    task automatic t_strap;
        logic [7:0] v;
        hw_reset(1'b1);
        iow(8'h4E, 8'h83); iow(8'h4E, 8'h83);
        chk("R4 strap1 high pair dead", 128'(cfg_mode), 128'd0);
        iow(8'h2E, 8'h83); iow(8'h2E, 8'h83);
        chk("R4 strap1 low pair", 128'(cfg_mode), 128'd1);
        iow(8'h2E, 8'h26); ior(8'h2F, v);
        chk("R4 opts reset strap1", 128'(v), 128'h00);
        iow(8'h2F, 8'h40);
        iow(8'h4E, 8'h26); ior(8'h4F, v);
        chk("R4 moved pair", 128'(v), 128'h40);
        ior(8'h2F, v);
        chk("R4 old pair silent", 128'(v), 128'h00);
        iow(8'h4E, 8'h02); iow(8'h4F, 8'h01);
        iow(8'h2E, 8'h26); ior(8'h2F, v);
        chk("R9 srst uses strap", 128'(v), 128'h00);
        chk("R9 mode after move", 128'(cfg_mode), 128'd1);
    endtask

    initial begin
        t_reset();
        t_unlock();
        t_closed();
        t_bank();
        t_global();
        t_soft();
        t_lock();
        t_strap();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule